// File: doc/BRIEF.md
# Serial Control Register Interface

This block lets a host configure a signal-processing core through a three-wire serial link: a serial clock, a data line and a latch strobe. The host shifts in an 8-bit command word, first bit first, and then pulses the latch strobe. The leading bits of the word select the target register. A word that starts with 0 loads a 7-bit attenuation code. Words that start with 1 load one of three mode-flag registers, selected by the next two bits. All three serial lines are sampled in the system clock domain. Two synchronizer flops on each line are followed by edge detection, so the serial clock has to be several times slower than the system clock.

A control-source select input picks where the flags come from. When it is HIGH, dedicated input pins drive the flags that have a pin, and serial writes are ignored. When it is LOW, the registers drive every flag. Flags without a pin always come from their registers. An active-low asynchronous reset loads the defaults as soon as it is asserted.

Top module: `ctl_serial_regs`

## Requirements
- R1: While `rstN` is LOW, and immediately after it falls, the registers hold their defaults: attenuation 0, syncMode 1, muteOff 1, dithOn 1, highSpeed 1, outLen 0, deemRate 2'b11, inLen 2'b01 (16-bit input), deemOn 0, modeSel 2'b11.
- R2: Each rising edge of `serClk` shifts `serData` into an 8-bit shift register. The word's bit 1 is sent first and bit 8 last. Each rising edge of `serLatch` acts on the last eight bits received.
- R3: A word whose bit 1 is 0 loads `attenOut` from bits 2..8, with bit 2 as the MSB.
- R4: A word whose bits 1..3 are 100 loads mode register 1. Bit 4 goes to syncMode, bit 5 to muteOff, bit 6 to dithOn, bit 7 to highSpeed and bit 8 to outLen.
- R5: A word whose bits 1..3 are 101 loads mode register 2. Bits 4..5 go to deemRate (bit 4 is the MSB), bits 6..7 go to inLen (bit 6 is the MSB), and bit 8 goes to deemOn.
- R6: A word whose bits 1..3 are 110 loads modeSel from bits 4..5 (bit 4 is the MSB). Bits 6..8 of that word have no effect.
- R7: A word whose bits 1..3 are 111 changes no register.
- R8: While `pinCtl` is HIGH, syncMode, dithOn, deemOn, outLen, highSpeed and modeSel follow `pinSync`, `pinDith`, `pinDeem`, `pinOutLen`, `pinHs` and `pinModeSel` combinationally. attenOut, muteOff, deemRate and inLen keep showing their register values.
- R9: A latch pulse while `pinCtl` is HIGH changes no register. This is visible once `pinCtl` returns LOW.
- R10: If more than eight bits are sent before a latch, only the last eight take effect.
- R11: Asserting `rstN` in the middle of a word restores the R1 defaults at the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock (asynchronous) |
| serData | input | 1 | Serial data, bit 1 first |
| serLatch | input | 1 | Latch strobe, acts on its rising edge |
| pinCtl | input | 1 | HIGH: pin-backed flags come from pins and writes are blocked |
| pinSync | input | 1 | Pin value for syncMode |
| pinDith | input | 1 | Pin value for dithOn |
| pinDeem | input | 1 | Pin value for deemOn |
| pinHs | input | 1 | Pin value for highSpeed |
| pinOutLen | input | 1 | Pin value for outLen |
| pinModeSel | input | 2 | Pin value for modeSel |
| attenOut | output | 7 | Attenuation code |
| syncMode | output | 1 | Sync/jitter-free select |
| muteOff | output | 1 | 1 = muting off |
| dithOn | output | 1 | Dither rounding enable |
| deemOn | output | 1 | Deemphasis enable |
| deemRate | output | 2 | Deemphasis rate code |
| inLen | output | 2 | Input length code (00=32, 01=16, 10=24, 11=20 bits) |
| outLen | output | 1 | Output length (1=24, 0=20 bits) |
| highSpeed | output | 1 | High-speed sampling select |
| modeSel | output | 2 | Operating-mode selects |

## Verification
A wrong bit in the shift register stays hidden until the next latch pulse. At that point it lands in the wrong field, or the wrong register, within three system clocks of the latch edge. Any faulty decode or field wiring therefore shows up as a mismatch in the full output vector after one word. Each address gets an exhaustive payload sweep, so every field bit is driven to both values and compared against the other fields. Pin-mode routing is combinational and is checked at once over all pin combinations. A write that leaked through while writes were blocked only appears when the control source switches back to the registers, so the bench compares right after that switch.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  localparam int WORD_W = 8;
  localparam int ATT_W  = WORD_W - 1;
  localparam int ADDR_W = 3;
  localparam int PAY_W  = WORD_W - ADDR_W;

  typedef struct packed {
    logic shift;
    logic dataBit;
    logic latch;
  } ctlStrobe_t;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MODE1 = 3'b100,
    ADDR_MODE2 = 3'b101,
    ADDR_MODE3 = 3'b110,
    ADDR_SPARE = 3'b111
  } modeAddr_t;

  typedef struct packed {
    logic       syncMode;
    logic       muteOff;
    logic       dithOn;
    logic       highSpeed;
    logic       outLen;
    logic [1:0] deemRate;
    logic [1:0] inLen;
    logic       deemOn;
    logic [1:0] modeSel;
  } modeFlags_t;

  localparam modeFlags_t FLAGS_DEFAULT = '{
    syncMode: 1'b1, muteOff: 1'b1, dithOn: 1'b1, highSpeed: 1'b1,
    outLen: 1'b0, deemRate: 2'b11, inLen: 2'b01, deemOn: 1'b0,
    modeSel: 2'b11
  };
endpackage

// File: rtl/ctl_serial_ctrl.sv
module ctl_serial_ctrl
  import ctl_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serLatch,
  output ctlStrobe_t strobe
);
  localparam int NLINE = 3;
  localparam int CLK_I = 2;
  localparam int DAT_I = 1;
  localparam int LAT_I = 0;

  logic [NLINE-1:0] rawLines;
  logic [SYNC_STAGES-1:0][NLINE-1:0] syncStage;
  logic [NLINE-1:0] syncd;
  logic clkPrev;
  logic latchPrev;

  assign rawLines = {serClk, serData, serLatch};
  assign syncd    = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage <= '0;
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      syncStage[0] <= rawLines;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
      clkPrev   <= syncd[CLK_I];
      latchPrev <= syncd[LAT_I];
    end
  end

  always_comb begin
    strobe.shift   = syncd[CLK_I] & ~clkPrev;
    strobe.dataBit = syncd[DAT_I];
    strobe.latch   = syncd[LAT_I] & ~latchPrev;
  end
endmodule

// File: rtl/ctl_serial_dp.sv
module ctl_serial_dp
  import ctl_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              writeBlock,
  output logic [WORD_W-1:0] shiftWord,
  output logic [ATT_W-1:0]  attReg,
  output modeFlags_t        flagReg
);
  logic [ADDR_W-1:0] addrBits;
  logic [PAY_W-1:0]  payload;
  logic wrEn;
  logic wrAtt;
  logic wrMode1;
  logic wrMode2;
  logic wrMode3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftWord <= '0;
    else if (strobe.shift) shiftWord <= {shiftWord[WORD_W-2:0], strobe.dataBit};
  end

  always_comb begin
    addrBits = shiftWord[WORD_W-1 -: ADDR_W];
    payload  = shiftWord[PAY_W-1:0];
    wrEn     = strobe.latch & ~writeBlock;
    wrAtt    = wrEn & ~shiftWord[WORD_W-1];
    wrMode1  = wrEn & (addrBits == ADDR_MODE1);
    wrMode2  = wrEn & (addrBits == ADDR_MODE2);
    wrMode3  = wrEn & (addrBits == ADDR_MODE3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attReg  <= '0;
      flagReg <= FLAGS_DEFAULT;
    end else begin
      if (wrAtt) attReg <= shiftWord[ATT_W-1:0];
      if (wrMode1) begin
        flagReg.syncMode  <= payload[4];
        flagReg.muteOff   <= payload[3];
        flagReg.dithOn    <= payload[2];
        flagReg.highSpeed <= payload[1];
        flagReg.outLen    <= payload[0];
      end
      if (wrMode2) begin
        flagReg.deemRate <= payload[4:3];
        flagReg.inLen    <= payload[2:1];
        flagReg.deemOn   <= payload[0];
      end
      if (wrMode3) flagReg.modeSel <= payload[4:3];
    end
  end
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
  import ctl_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serLatch,
  input  logic       pinCtl,
  input  logic       pinSync,
  input  logic       pinDith,
  input  logic       pinDeem,
  input  logic       pinHs,
  input  logic       pinOutLen,
  input  logic [1:0] pinModeSel,
  output logic [6:0] attenOut,
  output logic       syncMode,
  output logic       muteOff,
  output logic       dithOn,
  output logic       deemOn,
  output logic [1:0] deemRate,
  output logic [1:0] inLen,
  output logic       outLen,
  output logic       highSpeed,
  output logic [1:0] modeSel
);
  ctlStrobe_t        strobeBus;
  logic [WORD_W-1:0] shiftWord;
  logic [ATT_W-1:0]  attReg;
  modeFlags_t        flagReg;

  ctl_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .strobe(strobeBus)
  );

  ctl_serial_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobeBus), .writeBlock(pinCtl),
    .shiftWord(shiftWord), .attReg(attReg), .flagReg(flagReg)
  );

  always_comb begin
    attenOut  = attReg;
    muteOff   = flagReg.muteOff;
    deemRate  = flagReg.deemRate;
    inLen     = flagReg.inLen;
    syncMode  = pinCtl ? pinSync    : flagReg.syncMode;
    dithOn    = pinCtl ? pinDith    : flagReg.dithOn;
    deemOn    = pinCtl ? pinDeem    : flagReg.deemOn;
    outLen    = pinCtl ? pinOutLen  : flagReg.outLen;
    highSpeed = pinCtl ? pinHs      : flagReg.highSpeed;
    modeSel   = pinCtl ? pinModeSel : flagReg.modeSel;
  end
endmodule

// File: rtl/ctl_serial_regs_chk.sv
module ctl_serial_regs_chk
  import ctl_serial_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pinCtl,
  input ctlStrobe_t        strobeBus,
  input logic [WORD_W-1:0] shiftWord,
  input logic [ATT_W-1:0]  attReg,
  input modeFlags_t        flagReg
);
  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_defaults_chk: assert (attReg == '0 && flagReg == FLAGS_DEFAULT);
    end
  end

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeBus.shift |=> $stable(shiftWord));

  // R2
  shift_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeBus.shift |=> shiftWord[0] == $past(strobeBus.dataBit));

  // R3
  att_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeBus.latch && !pinCtl && !shiftWord[WORD_W-1] |=> attReg == $past(shiftWord[ATT_W-1:0]));

  // R7
  spare_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeBus.latch && shiftWord[WORD_W-1 -: ADDR_W] == 3'b111 |=> $stable(attReg) && $stable(flagReg));

  // R9
  write_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinCtl |=> $stable(attReg) && $stable(flagReg));
endmodule

bind ctl_serial_regs ctl_serial_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .pinCtl(pinCtl), .strobeBus(strobeBus),
  .shiftWord(shiftWord), .attReg(attReg), .flagReg(flagReg)
);

// File: tb/ctl_serial_regs_tb.sv
module ctl_serial_regs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic pinCtl = 1'b0, pinSync = 1'b0, pinDith = 1'b0, pinDeem = 1'b0;
  logic pinHs = 1'b0, pinOutLen = 1'b0;
  logic [1:0] pinModeSel = 2'b00;
  logic [6:0] attenOut;
  logic syncMode, muteOff, dithOn, deemOn, outLen, highSpeed;
  logic [1:0] deemRate, inLen, modeSel;

  int nChecks = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic [6:0] eAtt;
  logic eSync, eMuteOff, eDith, eHs, eOutLen, eDeem;
  logic [1:0] eRate, eInLen, eModeSel;

  always #2 clk = ~clk;

  ctl_serial_regs u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLatch(serLatch),
    .pinCtl(pinCtl), .pinSync(pinSync), .pinDith(pinDith), .pinDeem(pinDeem),
    .pinHs(pinHs), .pinOutLen(pinOutLen), .pinModeSel(pinModeSel),
    .attenOut(attenOut), .syncMode(syncMode), .muteOff(muteOff), .dithOn(dithOn),
    .deemOn(deemOn), .deemRate(deemRate), .inLen(inLen), .outLen(outLen),
    .highSpeed(highSpeed), .modeSel(modeSel)
  );

  task automatic modelReset();
    eAtt = 7'd0; eSync = 1'b1; eMuteOff = 1'b1; eDith = 1'b1; eHs = 1'b1;
    eOutLen = 1'b0; eRate = 2'b11; eInLen = 2'b01; eDeem = 1'b0; eModeSel = 2'b11;
  endtask

  task automatic modelWrite(input logic [7:0] w);
    if (pinCtl) return;
    if (!w[7]) eAtt = w[6:0];
    else case (w[7:5])
      3'b100: {eSync, eMuteOff, eDith, eHs, eOutLen} = w[4:0];
      3'b101: {eRate, eInLen, eDeem} = w[4:0];
      3'b110: eModeSel = w[4:3];
      default: ;
    endcase
  endtask

  function automatic logic [18:0] expVec();
    return {eAtt, pinCtl ? pinSync : eSync, eMuteOff, pinCtl ? pinDith : eDith,
            pinCtl ? pinDeem : eDeem, eRate, eInLen, pinCtl ? pinOutLen : eOutLen,
            pinCtl ? pinHs : eHs, pinCtl ? pinModeSel : eModeSel};
  endfunction

  function automatic logic [18:0] gotVec();
    return {attenOut, syncMode, muteOff, dithOn, deemOn, deemRate, inLen, outLen,
            highSpeed, modeSel};
  endfunction

  task automatic check(input string tag);
    logic [18:0] g, e;
    g = gotVec();
    e = expVec();
    nChecks++;
    if (g !== e) begin
      nBad++;
      $display("FAIL %s got=%05h exp=%05h", tag, g, e);
    end
  endtask

  task automatic sendBits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) serData = bits[i];
      repeat (3) @(negedge clk);
      serClk = 1'b1;
      repeat (3) @(negedge clk);
      serClk = 1'b0;
    end
  endtask

  task automatic pulseLatch();
    @(negedge clk) serLatch = 1'b1;
    repeat (3) @(negedge clk);
    serLatch = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic writeWord(input logic [7:0] w);
    sendBits({8'h00, w}, 8);
    pulseLatch();
    modelWrite(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    modelReset();
    #1 rstN = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 reset defaults");
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 defaults after release");

    // R3 and R2: every attenuation code
    for (int a = 0; a < 128; a++) begin
      writeWord({1'b0, a[6:0]});
      check("R3 attenuation code");
    end
    // R4: mode register 1 sweep
    for (int p = 0; p < 32; p++) begin
      writeWord({3'b100, p[4:0]});
      check("R4 mode1 payload");
    end
    // R5: mode register 2 sweep
    for (int p = 0; p < 32; p++) begin
      writeWord({3'b101, p[4:0]});
      check("R5 mode2 payload");
    end
    // R6: mode register 3 sweep, bits 6..8 have no effect
    for (int p = 0; p < 32; p++) begin
      writeWord({3'b110, p[4:0]});
      check("R6 mode3 payload");
    end
    // R7: spare address leaves every register alone
    writeWord(8'h2A);
    writeWord(8'h9F);
    for (int p = 0; p < 32; p++) begin
      writeWord({3'b111, p[4:0]});
      check("R7 spare address ignored");
    end
    // R10: longer burst, only the last eight bits count
    sendBits(16'h0F55, 12);
    pulseLatch();
    modelWrite(8'h55);
    check("R10 last eight bits");
    sendBits(16'hB3A1, 16);
    pulseLatch();
    modelWrite(8'hA1);
    check("R10 sixteen-bit burst");

    // R8: every pin combination in pin mode
    @(negedge clk) pinCtl = 1'b1;
    for (int p = 0; p < 128; p++) begin
      @(negedge clk);
      {pinSync, pinDith, pinDeem, pinHs, pinOutLen, pinModeSel} = p[6:0];
      #1 check("R8 pin routing");
    end
    // R9: writes blocked in pin mode
    writeWord(8'h3C);
    writeWord(8'h80);
    writeWord(8'hBF);
    writeWord(8'hC0);
    check("R9 pin mode after writes");
    @(negedge clk) pinCtl = 1'b0;
    #1 check("R9 registers untouched");

    // R11: reset in the middle of a word
    writeWord(8'h11);
    writeWord(8'h80);
    sendBits(16'h0005, 4);
    #1 rstN = 1'b0;
    modelReset();
    #0.5 check("R11 async reset mid-word");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 defaults after release");
    writeWord(8'h42);
    check("R2 write after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule